// File: doc/BRIEF.md
# Reorder Buffer with Youngest-Writer Operand Search

This block is the in-order retirement queue of a dual-issue out-of-order core. It is a circular buffer of 16 entries. Up to two instructions are given slots at the tail in each cycle, in program order. Execution units later report each result on a tagged result bus, and the slot named by the tag records the value and any exception. The oldest slot retires to the architectural register file once its result is in and clean. The first exception that reaches the oldest slot empties the whole buffer and reports the program counter of the faulting instruction.

Each cycle, four operand ports (two sources for each of two instructions) ask whether an in-flight instruction will write a given register. Several live slots may target the same register. The search walks from the oldest slot to the youngest with wrap-around, so the most recent writer wins. A port then returns the value if that writer has finished, the slot tag if it has not, or a miss, which sends the requester to the register file. A flush input keeps every slot up to a given tag and discards all younger slots.

Top module: `rob_assoc`

## Requirements
- R1: After reset the buffer is empty. No retire or trap is signalled, every lookup misses, and a two-lane request is granted at once with tags 0 and 1.
- R2: Grants and tags are combinational in the request cycle. Lane 0 takes the tail slot. Lane 1 takes the tail plus one when lane 0 also requests, and the tail slot itself when it requests alone.
- R3: A lane is granted only if a free slot remains for it. With one slot free, only lane 0 of a pair is granted. With the buffer holding 16 live slots, no lane is granted.
- R4: A result-bus write with tag t to a live slot marks it complete. From the next cycle on, a lookup that selects t reports ready together with the written value.
- R5: A lookup of a register that no live slot targets reports no hit.
- R6: When several live slots target the looked-up register, the port returns the tag of the youngest in program order, including when that slot's index has wrapped below the older ones.
- R7: A hit on a slot that has not completed reports hit with ready low, plus that slot's tag.
- R8: When the oldest slot is complete without exception, the retire output is high in the same cycle with its destination and value. The next slot in order may retire in the following cycle.
- R9: Nothing retires while the oldest slot is incomplete, even when younger slots have completed.
- R10: When the oldest slot completes with an exception, the trap output is high with that slot's PC and there is no retire. From the next cycle the buffer is empty, and the next grant reuses the old oldest-slot index.
- R11: A flush with tag f keeps slots from the oldest through f and removes the younger ones. No grant is given in the flush cycle, and the next grant starts at f+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_req_i | input | 2 | Per-lane slot request, lane 0 older |
| alloc_dst_i | input | 2x6 | Per-lane destination register |
| alloc_pc_i | input | 2x32 | Per-lane instruction PC |
| alloc_gnt_o | output | 2 | Per-lane grant |
| alloc_tag_o | output | 2x4 | Per-lane slot index |
| cdb_valid_i | input | 1 | Result bus write strobe |
| cdb_tag_i | input | 4 | Slot written by the result bus |
| cdb_value_i | input | 32 | Result value |
| cdb_exc_i | input | 1 | Result carries an exception |
| lk_reg_i | input | 4x6 | Register searched by each operand port |
| lk_hit_o | output | 4 | A live slot targets the register |
| lk_ready_o | output | 4 | The selected slot has completed |
| lk_tag_o | output | 4x4 | Index of the selected slot |
| lk_value_o | output | 4x32 | Value of the selected slot when ready |
| commit_valid_o | output | 1 | Oldest slot retires this cycle |
| commit_dst_o | output | 6 | Register written by the retirement |
| commit_value_o | output | 32 | Value written by the retirement |
| trap_valid_o | output | 1 | Oldest slot retires as an exception |
| trap_pc_o | output | 32 | PC of the faulting instruction |
| flush_i | input | 1 | Discard slots younger than flush_tag_i |
| flush_tag_i | input | 4 | Youngest slot kept by a flush |

## Verification
Grants and tags follow a request in the same cycle. Lookup answers, retire and trap outputs are combinational from stored state, so they reflect a result-bus write, grant or flush one rising edge after it is applied. The bench drives every input on the falling edge and samples 1 ns later, before the next rising edge. It therefore reads same-cycle grants before they take effect and reads state changes exactly one edge after their cause. Retirement and trap sequences are followed edge by edge to confirm that the oldest slot advances by exactly one.

// File: rtl/rob_pkg.sv
package rob_pkg;
  localparam int unsigned LANES = 2;

  typedef enum logic [1:0] {
    HEAD_EMPTY,
    HEAD_WAIT,
    HEAD_RETIRE,
    HEAD_TRAP
  } head_state_e;
endpackage

// File: rtl/rob_alloc_ctrl.sv
module rob_alloc_ctrl #(
  parameter  int unsigned DEPTH = 16,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = IDX_W + 1
) (
  input  logic [1:0]            req_i,
  input  logic [CNT_W-1:0]      count_i,
  input  logic [IDX_W-1:0]      tail_i,
  input  logic                  block_i,
  output logic [1:0]            gnt_o,
  output logic [1:0][IDX_W-1:0] slot_o,
  output logic [1:0]            n_alloc_o
);
  logic [CNT_W-1:0] free;

  always_comb begin
    free  = CNT_W'(DEPTH) - count_i;
    gnt_o = '0;
    if (!block_i) begin
      gnt_o[0] = req_i[0] && (free >= CNT_W'(1));
      // lane 1 only follows a granted lane 0, and needs room for both
      if (req_i[0]) gnt_o[1] = req_i[1] && gnt_o[0] && (free >= CNT_W'(2));
      else          gnt_o[1] = req_i[1] && (free >= CNT_W'(1));
    end
    slot_o[0] = tail_i;
    slot_o[1] = tail_i + IDX_W'(req_i[0]);
    n_alloc_o = 2'(gnt_o[0]) + 2'(gnt_o[1]);
  end
endmodule

// File: rtl/rob_head_ctrl.sv
module rob_head_ctrl
  import rob_pkg::*;
(
  input  logic        occupied_i,
  input  logic        done_i,
  input  logic        exc_i,
  output head_state_e state_o
);
  always_comb begin
    if (!occupied_i)  state_o = HEAD_EMPTY;
    else if (!done_i) state_o = HEAD_WAIT;
    else if (exc_i)   state_o = HEAD_TRAP;
    else              state_o = HEAD_RETIRE;
  end
endmodule

// File: rtl/rob_lookup_port.sv
module rob_lookup_port #(
  parameter  int unsigned DEPTH  = 16,
  parameter  int unsigned REG_W  = 6,
  parameter  int unsigned DATA_W = 32,
  localparam int unsigned IDX_W  = $clog2(DEPTH)
) (
  input  logic [IDX_W-1:0]             head_i,
  input  logic [DEPTH-1:0]             live_i,
  input  logic [DEPTH-1:0]             done_i,
  input  logic [DEPTH-1:0][REG_W-1:0]  dst_i,
  input  logic [DEPTH-1:0][DATA_W-1:0] val_i,
  input  logic [REG_W-1:0]             reg_i,
  output logic                         hit_o,
  output logic                         ready_o,
  output logic [IDX_W-1:0]             tag_o,
  output logic [DATA_W-1:0]            value_o
);
  logic [IDX_W-1:0] idx;

  // walk oldest to youngest from head; later match overrides earlier
  always_comb begin
    hit_o = 1'b0;
    tag_o = '0;
    idx   = '0;
    for (int a = 0; a < DEPTH; a++) begin
      idx = head_i + IDX_W'(a);
      if (live_i[idx] && (dst_i[idx] == reg_i)) begin
        hit_o = 1'b1;
        tag_o = idx;
      end
    end
    ready_o = hit_o && done_i[tag_o];
    value_o = ready_o ? val_i[tag_o] : '0;
  end
endmodule

// File: rtl/rob_assoc.sv
module rob_assoc
  import rob_pkg::*;
#(
  parameter  int unsigned DEPTH    = 16,
  parameter  int unsigned NUM_REGS = 64,
  parameter  int unsigned DATA_W   = 32,
  parameter  int unsigned PC_W     = 32,
  parameter  int unsigned N_LOOKUP = 4,
  localparam int unsigned IDX_W    = $clog2(DEPTH),
  localparam int unsigned CNT_W    = IDX_W + 1,
  localparam int unsigned REG_W    = $clog2(NUM_REGS)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [LANES-1:0]                 alloc_req_i,
  input  logic [LANES-1:0][REG_W-1:0]      alloc_dst_i,
  input  logic [LANES-1:0][PC_W-1:0]       alloc_pc_i,
  output logic [LANES-1:0]                 alloc_gnt_o,
  output logic [LANES-1:0][IDX_W-1:0]      alloc_tag_o,
  input  logic                             cdb_valid_i,
  input  logic [IDX_W-1:0]                 cdb_tag_i,
  input  logic [DATA_W-1:0]                cdb_value_i,
  input  logic                             cdb_exc_i,
  input  logic [N_LOOKUP-1:0][REG_W-1:0]   lk_reg_i,
  output logic [N_LOOKUP-1:0]              lk_hit_o,
  output logic [N_LOOKUP-1:0]              lk_ready_o,
  output logic [N_LOOKUP-1:0][IDX_W-1:0]   lk_tag_o,
  output logic [N_LOOKUP-1:0][DATA_W-1:0]  lk_value_o,
  output logic                             commit_valid_o,
  output logic [REG_W-1:0]                 commit_dst_o,
  output logic [DATA_W-1:0]                commit_value_o,
  output logic                             trap_valid_o,
  output logic [PC_W-1:0]                  trap_pc_o,
  input  logic                             flush_i,
  input  logic [IDX_W-1:0]                 flush_tag_i
);
  logic [IDX_W-1:0] head_q, tail_q, head_d, tail_d, flush_dist;
  logic [CNT_W-1:0] count_q, count_d;
  logic [DEPTH-1:0] done_q, exc_q, live;
  logic [DEPTH-1:0][REG_W-1:0]  dst_q;
  logic [DEPTH-1:0][DATA_W-1:0] val_q;
  logic [DEPTH-1:0][PC_W-1:0]   pc_q;
  logic [1:0] n_alloc;
  logic       retire, trap, cdb_hit;
  head_state_e head_state;

  always_comb begin
    for (int i = 0; i < DEPTH; i++)
      live[i] = {1'b0, IDX_W'(IDX_W'(i) - head_q)} < count_q;
  end

  rob_head_ctrl u_head (
    .occupied_i (count_q != '0),
    .done_i     (done_q[head_q]),
    .exc_i      (exc_q[head_q]),
    .state_o    (head_state)
  );

  assign retire = (head_state == HEAD_RETIRE);
  assign trap   = (head_state == HEAD_TRAP);

  rob_alloc_ctrl #(.DEPTH(DEPTH)) u_alloc (
    .req_i     (alloc_req_i),
    .count_i   (count_q),
    .tail_i    (tail_q),
    .block_i   (flush_i || trap),
    .gnt_o     (alloc_gnt_o),
    .slot_o    (alloc_tag_o),
    .n_alloc_o (n_alloc)
  );

  for (genvar p = 0; p < N_LOOKUP; p++) begin : g_lookup
    rob_lookup_port #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W)) u_port (
      .head_i  (head_q),
      .live_i  (live),
      .done_i  (done_q),
      .dst_i   (dst_q),
      .val_i   (val_q),
      .reg_i   (lk_reg_i[p]),
      .hit_o   (lk_hit_o[p]),
      .ready_o (lk_ready_o[p]),
      .tag_o   (lk_tag_o[p]),
      .value_o (lk_value_o[p])
    );

    a_r6_hit_targets_live_writer: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lk_hit_o[p] |-> (live[lk_tag_o[p]] && (dst_q[lk_tag_o[p]] == lk_reg_i[p])));
    a_r7_ready_means_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lk_ready_o[p] |-> (lk_hit_o[p] && done_q[lk_tag_o[p]]));
  end

  always_comb begin
    flush_dist = flush_tag_i - head_q;
    head_d  = head_q + IDX_W'(retire);
    tail_d  = tail_q + IDX_W'(n_alloc);
    count_d = count_q + CNT_W'(n_alloc) - CNT_W'(retire);
    if (trap) begin
      head_d  = head_q;
      tail_d  = head_q;
      count_d = '0;
    end else if (flush_i) begin
      tail_d  = flush_tag_i + IDX_W'(1);
      count_d = CNT_W'(flush_dist) + CNT_W'(1) - CNT_W'(retire);
    end
  end

  assign cdb_hit = cdb_valid_i && live[cdb_tag_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
      done_q  <= '0;
      exc_q   <= '0;
    end else begin
      head_q  <= head_d;
      tail_q  <= tail_d;
      count_q <= count_d;
      if (cdb_hit) begin
        done_q[cdb_tag_i] <= 1'b1;
        exc_q[cdb_tag_i]  <= cdb_exc_i;
      end
      for (int l = 0; l < LANES; l++) begin
        if (alloc_gnt_o[l]) begin
          done_q[alloc_tag_o[l]] <= 1'b0;
          exc_q[alloc_tag_o[l]]  <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (cdb_hit) val_q[cdb_tag_i] <= cdb_value_i;
    for (int l = 0; l < LANES; l++) begin
      if (alloc_gnt_o[l]) begin
        dst_q[alloc_tag_o[l]] <= alloc_dst_i[l];
        pc_q[alloc_tag_o[l]]  <= alloc_pc_i[l];
      end
    end
  end

  assign commit_valid_o = retire;
  assign commit_dst_o   = dst_q[head_q];
  assign commit_value_o = val_q[head_q];
  assign trap_valid_o   = trap;
  assign trap_pc_o      = pc_q[head_q];

  a_r3_count_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CNT_W'(DEPTH));
  a_r3_no_grant_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_q == CNT_W'(DEPTH)) |-> (alloc_gnt_o == '0));
  a_r2_lane_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_gnt_o[1] && alloc_req_i[0]) |-> alloc_gnt_o[0]);
  a_r9_retire_needs_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_valid_o |-> (done_q[head_q] && !exc_q[head_q] && !trap_valid_o));
  a_r8_head_steps_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_valid_o |=> (head_q == IDX_W'($past(head_q) + 1'b1)));
  a_r10_trap_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_valid_o |=> (count_q == '0));
  a_r11_flush_sets_tail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_i && !trap_valid_o) |=> (tail_q == IDX_W'($past(flush_tag_i) + 1'b1)));
endmodule

// File: tb/rob_assoc_test.sv
`timescale 1ns/1ps
module rob_assoc_test;
  logic              clk = 1'b0;
  logic              rst_ni;
  logic [1:0]        alloc_req;
  logic [1:0][5:0]   alloc_dst;
  logic [1:0][31:0]  alloc_pc;
  logic [1:0]        alloc_gnt;
  logic [1:0][3:0]   alloc_tag;
  logic              cdb_valid, cdb_exc;
  logic [3:0]        cdb_tag;
  logic [31:0]       cdb_value;
  logic [3:0][5:0]   lk_reg;
  logic [3:0]        lk_hit, lk_ready;
  logic [3:0][3:0]   lk_tag;
  logic [3:0][31:0]  lk_value;
  logic              commit_valid, trap_valid, flush;
  logic [5:0]        commit_dst;
  logic [31:0]       commit_value, trap_pc;
  logic [3:0]        flush_tag;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [1:0] g;
  logic [3:0] t0, t1;

  always #2.5 clk = ~clk;

  rob_assoc uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .alloc_req_i(alloc_req), .alloc_dst_i(alloc_dst), .alloc_pc_i(alloc_pc),
    .alloc_gnt_o(alloc_gnt), .alloc_tag_o(alloc_tag),
    .cdb_valid_i(cdb_valid), .cdb_tag_i(cdb_tag), .cdb_value_i(cdb_value), .cdb_exc_i(cdb_exc),
    .lk_reg_i(lk_reg), .lk_hit_o(lk_hit), .lk_ready_o(lk_ready), .lk_tag_o(lk_tag), .lk_value_o(lk_value),
    .commit_valid_o(commit_valid), .commit_dst_o(commit_dst), .commit_value_o(commit_value),
    .trap_valid_o(trap_valid), .trap_pc_o(trap_pc),
    .flush_i(flush), .flush_tag_i(flush_tag)
  );

  // row: {reg[43:38], hit[37], ready[36], tag[35:32], value[31:0]}
  localparam logic [43:0] LK_TAB [6] = '{
    {6'd5,  1'b1, 1'b0, 4'd2, 32'h0},
    {6'd7,  1'b1, 1'b1, 4'd4, 32'hE4},
    {6'd9,  1'b1, 1'b1, 4'd3, 32'hD3},
    {6'd0,  1'b0, 1'b0, 4'd0, 32'h0},
    {6'd63, 1'b0, 1'b0, 4'd0, 32'h0},
    {6'd6,  1'b0, 1'b0, 4'd0, 32'h0}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic alloc_step(input logic [1:0] req, input logic [5:0] d0, input logic [5:0] d1,
                            input logic [31:0] p0, input logic [31:0] p1);
    alloc_req = req; alloc_dst[0] = d0; alloc_dst[1] = d1; alloc_pc[0] = p0; alloc_pc[1] = p1;
    #1;
    g = alloc_gnt; t0 = alloc_tag[0]; t1 = alloc_tag[1];
    @(negedge clk);
    alloc_req = '0;
  endtask

  task automatic cdb_step(input logic [3:0] tag, input logic [31:0] val, input logic exc);
    cdb_valid = 1'b1; cdb_tag = tag; cdb_value = val; cdb_exc = exc;
    @(negedge clk);
    cdb_valid = 1'b0; cdb_exc = 1'b0;
  endtask

  initial begin
    rst_ni = 1'b0; alloc_req = '0; alloc_dst = '0; alloc_pc = '0;
    cdb_valid = 1'b0; cdb_tag = '0; cdb_value = '0; cdb_exc = 1'b0;
    lk_reg = '0; flush = 1'b0; flush_tag = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    lk_reg[0] = 6'd5;
    #1;
    chk("R1 reset commit", commit_valid, 0);
    chk("R1 reset trap", trap_valid, 0);
    chk("R1 reset lookup miss", lk_hit[0], 0);
    @(negedge clk);

    alloc_step(2'b11, 6'd5, 6'd7, 32'h100, 32'h104);
    chk("R1 first pair granted", g, 2'b11);
    chk("R2 pair tags", {t0, t1}, {4'd0, 4'd1});
    alloc_step(2'b11, 6'd5, 6'd9, 32'h108, 32'h10C);
    chk("R2 second pair tags", {t0, t1}, {4'd2, 4'd3});
    alloc_step(2'b01, 6'd7, 6'd0, 32'h110, 32'h0);
    chk("R2 lane0 alone", {g, t0}, {2'b01, 4'd4});

    cdb_step(4'd1, 32'hB1, 1'b0);
    cdb_step(4'd3, 32'hD3, 1'b0);
    cdb_step(4'd4, 32'hE4, 1'b0);

    // table walk: R4 ready/value, R5 miss, R6 youngest, R7 pending tag
    for (int r = 0; r < 6; r++) begin
      lk_reg[r % 4] = LK_TAB[r][43:38];
      #1;
      chk("R5 R6 table hit", lk_hit[r % 4], LK_TAB[r][37]);
      chk("R4 R7 table ready", lk_ready[r % 4], LK_TAB[r][36]);
      if (LK_TAB[r][37]) chk("R6 table tag", lk_tag[r % 4], LK_TAB[r][35:32]);
      if (LK_TAB[r][36]) chk("R4 table value", lk_value[r % 4], LK_TAB[r][31:0]);
    end
    chk("R9 head pending no retire", commit_valid, 0);

    cdb_step(4'd0, 32'hA0, 1'b0);
    #1;
    chk("R8 retire head", {commit_valid, commit_dst, commit_value}, {1'b1, 6'd5, 32'hA0});
    @(negedge clk); #1;
    chk("R8 retire next", {commit_valid, commit_dst, commit_value}, {1'b1, 6'd7, 32'hB1});
    @(negedge clk); #1;
    chk("R9 stop at pending", commit_valid, 0);

    // flush keeping slot 2 only
    flush = 1'b1; flush_tag = 4'd2; alloc_req = 2'b11;
    #1;
    chk("R11 no grant in flush", alloc_gnt, 2'b00);
    @(negedge clk);
    flush = 1'b0; alloc_req = '0;
    lk_reg[0] = 6'd9; lk_reg[1] = 6'd7; lk_reg[2] = 6'd5;
    #1;
    chk("R11 flushed reg9", lk_hit[0], 0);
    chk("R11 flushed reg7", lk_hit[1], 0);
    chk("R11 kept slot", {lk_hit[2], lk_ready[2], lk_tag[2]}, {1'b1, 1'b0, 4'd2});
    alloc_step(2'b11, 6'd20, 6'd21, 32'h200, 32'h204);
    chk("R11 tags after flush", {g, t0, t1}, {2'b11, 4'd3, 4'd4});

    for (int k = 0; k < 6; k++) begin
      if (k == 4)      alloc_step(2'b11, 6'd40, 6'd31, 32'h300, 32'h304);
      else if (k == 5) alloc_step(2'b11, 6'd40, 6'd41, 32'h308, 32'h30C);
      else             alloc_step(2'b11, 6'd30, 6'd31, 32'h310, 32'h314);
      chk("R3 room for pair", g, 2'b11);
    end
    alloc_step(2'b11, 6'd40, 6'd42, 32'h320, 32'h324);
    chk("R3 one slot left", {g, t0}, {2'b01, 4'd1});
    alloc_step(2'b01, 6'd43, 6'd0, 32'h0, 32'h0);
    chk("R3 full lane0", g, 2'b00);
    alloc_step(2'b10, 6'd0, 6'd43, 32'h0, 32'h0);
    chk("R3 full lane1", g, 2'b00);

    lk_reg[0] = 6'd40; lk_reg[1] = 6'd41; lk_reg[2] = 6'd5; lk_reg[3] = 6'd42;
    #1;
    chk("R6 wrapped youngest", {lk_hit[0], lk_tag[0]}, {1'b1, 4'd1});
    chk("R6 single writer", {lk_hit[1], lk_tag[1]}, {1'b1, 4'd0});
    chk("R7 pending hit", {lk_hit[2], lk_ready[2], lk_tag[2]}, {1'b1, 1'b0, 4'd2});
    chk("R5 denied lane miss", lk_hit[3], 0);

    cdb_step(4'd2, 32'h55, 1'b1);
    #1;
    chk("R10 trap raised", {trap_valid, trap_pc}, {1'b1, 32'h108});
    chk("R10 no retire on trap", commit_valid, 0);
    @(negedge clk); #1;
    chk("R10 trap cleared", trap_valid, 0);
    chk("R10 buffer emptied", lk_hit[0], 0);
    alloc_step(2'b10, 6'd0, 6'd50, 32'h0, 32'h400);
    chk("R2 lane1 alone at head", {g, t1}, {2'b10, 4'd2});

    cdb_step(4'd2, 32'h77, 1'b0);
    lk_reg[0] = 6'd50;
    #1;
    chk("R4 ready after write", {lk_hit[0], lk_ready[0], lk_tag[0], lk_value[0]},
        {1'b1, 1'b1, 4'd2, 32'h77});
    chk("R8 retire after trap", {commit_valid, commit_dst, commit_value}, {1'b1, 6'd50, 32'h77});
    @(negedge clk);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule